// File: doc/BRIEF.md
# Machine-Cycle Sequenced Increment Core

This block is a small 8-bit processor that runs only two kinds of one-byte instruction: a no-operation and an increment. The increment target is one of seven registers or the memory byte addressed by the H:L register pair. The core holds seven 8-bit registers (B, C, D, E, H, L, A), an 8-bit flag register and a 16-bit program counter. Each instruction is fetched from a simple synchronous memory, one byte per opcode fetch.

Every instruction is paced as a chain of machine cycles. Each machine cycle is a fixed number of T-states, and each T-state lasts one clock. An opcode fetch takes four T-states. A memory read or a memory write takes three. Register increments complete inside the fetch. A memory increment chains fetch, read and write, for ten T-states in all. The current machine-cycle type and T-state number are driven out so a system can follow the bus. The register file and the flags are also driven out as the architectural view of the core.

Top module: `incr_core`

## Requirements
- R1: While rst_n is low and right after its release, all registers, the flags and the program counter are zero, mcycle shows opcode fetch (01), tstate is 1, mem_addr is 0000H and mem_wr is low.
- R2: Opcode 00H takes a single opcode fetch of 4 T-states and changes no register and no flag.
- R3: An opcode of the form 00DDD100 with DDD other than 110 adds one to register DDD (B=000, C=001, D=010, E=011, H=100, L=101, A=111) within its 4-T-state fetch. The result replaces the old value. arch_regs carries register code k in bits 8k+7:8k, and byte 6 reads zero.
- R4: Opcode 34H runs an opcode fetch, then a memory read, then a memory write, for 10 T-states in all. Both memory cycles address the byte at {H,L}, and the write stores the read value plus one. No register changes.
- R5: Every increment sets the flags from the result: bit 7 is the sign, bit 6 is zero, bit 4 is the carry out of bit 3, and bit 2 is set when the number of ones is even. Bit 0 (carry) keeps its value, and bits 5, 3 and 1 are zero.
- R6: Incrementing FFH gives 00H with the zero and half-carry flags set and carry unchanged, for both a register and a memory target.
- R7: Any opcode that is neither 00H nor one of the eight increments runs exactly like 00H.
- R8: mcycle encodes fetch=01, read=10, write=11. tstate counts 1,2,3,4 in a fetch and 1,2,3 in a read or write, and it restarts at 1 with each new machine cycle.
- R9: mem_rd is high in T1 to T3 of a fetch and in all of a read. mem_wr is high in all of a write, with mem_wdata valid. The two strobes are never high together.
- R10: The program counter advances by one per opcode fetch, so each fetch addresses the byte after the previous fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Memory address: PC in a fetch, {H,L} in a read or write |
| mem_rdata | input | 8 | Read data, sampled at the end of T3 |
| mem_wdata | output | 8 | Write data during a write cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mcycle | output | 2 | Machine-cycle type: 01 fetch, 10 read, 11 write |
| tstate | output | 3 | Current T-state number, starting at 1 |
| arch_regs | output | 64 | Register file view, byte k = register code k |
| flags | output | 8 | Flag register |

## Verification
The hardest state to reach is the wrap of a register from FFH to 00H, because the only way to load a register is to increment it. The bench fills memory with 256 copies of the B increment and checks B and the flags after the 255th and the 256th step. Memory wraps are reached by preloading FFH and 7FH at H:L targets that the program first sets up by incrementing H and L. The bench compares the machine-cycle and T-state outputs on every clock of each instruction. This shows each new machine cycle restarting at T1.

// File: rtl/incr_pkg.sv
package incr_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 16;
  localparam int TS_W     = 3;
  localparam int FETCH_TS = 4;
  localparam int MEM_TS   = 3;
  localparam int NREG     = 8;
  localparam int SEL_W    = $clog2(NREG);

  localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;
  localparam logic [SEL_W-1:0] SEL_H   = 3'd4;
  localparam logic [SEL_W-1:0] SEL_L   = 3'd5;

  localparam int F_SIGN = 7;
  localparam int F_ZERO = 6;
  localparam int F_HALF = 4;
  localparam int F_PAR  = 2;
  localparam int F_CY   = 0;

  typedef enum logic [1:0] {
    MC_FETCH = 2'b01,
    MC_READ  = 2'b10,
    MC_WRITE = 2'b11
  } mcyc_e;

  function automatic logic is_incr(input logic [DATA_W-1:0] op);
    return (op[7:6] == 2'b00) && (op[2:0] == 3'b100);
  endfunction

  function automatic logic [DATA_W-1:0] incr_value(input logic [DATA_W-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] incr_flags(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] old_f);
    logic [DATA_W-1:0] r;
    logic [DATA_W-1:0] f;
    r = old_v + 1'b1;
    f = '0;
    f[F_SIGN] = r[DATA_W-1];
    f[F_ZERO] = (r == '0);
    f[F_HALF] = (old_v[3:0] == 4'hF);
    f[F_PAR]  = ~^r;
    f[F_CY]   = old_f[F_CY];
    return f;
  endfunction
endpackage

// File: rtl/incr_seq.sv
module incr_seq
  import incr_pkg::*;
#(
  parameter int TSW      = TS_W,
  parameter int FETCH_LN = FETCH_TS,
  parameter int MEM_LN   = MEM_TS
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           want_mem_i,
  output mcyc_e          mc_o,
  output logic [TSW-1:0] ts_o,
  output logic           cyc_end_o
);
  localparam logic [TSW-1:0] FETCH_LAST = TSW'(FETCH_LN);
  localparam logic [TSW-1:0] MEM_LAST   = TSW'(MEM_LN);
  localparam logic [TSW-1:0] T_FIRST    = TSW'(1);

  mcyc_e          mc_q, mc_d;
  logic [TSW-1:0] ts_q;
  logic [TSW-1:0] last_t;

  assign last_t    = (mc_q == MC_FETCH) ? FETCH_LAST : MEM_LAST;
  assign cyc_end_o = (ts_q == last_t);

  always_comb begin
    unique case (mc_q)
      MC_FETCH: mc_d = want_mem_i ? MC_READ : MC_FETCH;
      MC_READ:  mc_d = MC_WRITE;
      default:  mc_d = MC_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc_q <= MC_FETCH;
      ts_q <= T_FIRST;
    end else if (cyc_end_o) begin
      mc_q <= mc_d;
      ts_q <= T_FIRST;
    end else begin
      ts_q <= ts_q + 1'b1;
    end
  end

  assign mc_o = mc_q;
  assign ts_o = ts_q;
endmodule

// File: rtl/incr_alu.sv
module incr_alu
  import incr_pkg::*;
#(
  parameter int DW = DATA_W
)(
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] flags_i,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] flags_o
);
  assign res_o   = incr_value(val_i);
  assign flags_o = incr_flags(val_i, flags_i);
endmodule

// File: rtl/incr_regfile.sv
module incr_regfile
  import incr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NREG,
  parameter int SW = SEL_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SW-1:0]    wsel_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [SW-1:0]    rsel_i,
  output logic [DW-1:0]    rdata_o,
  output logic [2*DW-1:0]  hl_o,
  output logic [NR*DW-1:0] view_o
);
  logic [DW-1:0] regs [NR];

  for (genvar g = 0; g < NR; g++) begin : g_reg
    if (g == int'(SEL_MEM)) begin : g_hole
      assign regs[g] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                          q <= '0;
        else if (we_i && wsel_i == SW'(g))   q <= wdata_i;
      end
      assign regs[g] = q;
    end
    assign view_o[g*DW +: DW] = regs[g];
  end

  assign rdata_o = regs[rsel_i];
  assign hl_o    = {regs[SEL_H], regs[SEL_L]};
endmodule

// File: rtl/incr_core.sv
module incr_core
  import incr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic [DATA_W-1:0]      mem_wdata,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic [1:0]             mcycle,
  output logic [TS_W-1:0]        tstate,
  output logic [NREG*DATA_W-1:0] arch_regs,
  output logic [DATA_W-1:0]      flags
);
  localparam logic [TS_W-1:0] T_CAPTURE = TS_W'(3);
  localparam logic [TS_W-1:0] T_FIRST   = TS_W'(1);

  mcyc_e               mc;
  logic [TS_W-1:0]     ts;
  logic                cyc_end;
  logic [ADDR_W-1:0]   pc_q;
  logic [DATA_W-1:0]   ir_q;
  logic [DATA_W-1:0]   tmp_q;
  logic [DATA_W-1:0]   flag_q;
  logic [SEL_W-1:0]    dsel;
  logic                op_incr, op_incr_mem, op_incr_reg;
  logic [DATA_W-1:0]   rf_rdata;
  logic [2*DATA_W-1:0] hl;
  logic [DATA_W-1:0]   alu_in, alu_res, alu_flags;

  // Named events, also observed by the bound checker.
  logic fetch_start, fetch_end, write_end, capture_now, rf_we, flag_we;

  incr_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .want_mem_i (op_incr_mem),
    .mc_o       (mc),
    .ts_o       (ts),
    .cyc_end_o  (cyc_end)
  );

  assign dsel        = ir_q[5:3];
  assign op_incr     = is_incr(ir_q);
  assign op_incr_mem = op_incr && (dsel == SEL_MEM);
  assign op_incr_reg = op_incr && (dsel != SEL_MEM);

  assign fetch_start = (mc == MC_FETCH) && (ts == T_FIRST);
  assign fetch_end   = (mc == MC_FETCH) && cyc_end;
  assign write_end   = (mc == MC_WRITE) && cyc_end;
  assign capture_now = (mc != MC_WRITE) && (ts == T_CAPTURE);
  assign rf_we       = fetch_end && op_incr_reg;
  assign flag_we     = rf_we || write_end;

  incr_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (rf_we),
    .wsel_i  (dsel),
    .wdata_i (alu_res),
    .rsel_i  (dsel),
    .rdata_o (rf_rdata),
    .hl_o    (hl),
    .view_o  (arch_regs)
  );

  assign alu_in = (mc == MC_WRITE) ? tmp_q : rf_rdata;

  incr_alu u_alu (
    .val_i   (alu_in),
    .flags_i (flag_q),
    .res_o   (alu_res),
    .flags_o (alu_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ir_q   <= '0;
      tmp_q  <= '0;
      flag_q <= '0;
    end else begin
      if (capture_now && mc == MC_FETCH) ir_q  <= mem_rdata;
      if (capture_now && mc == MC_READ)  tmp_q <= mem_rdata;
      if (fetch_end)                     pc_q  <= pc_q + 1'b1;
      if (flag_we)                       flag_q <= alu_flags;
    end
  end

  assign mem_addr  = (mc == MC_FETCH) ? pc_q : hl;
  assign mem_wdata = (mc == MC_WRITE) ? alu_res : '0;
  assign mem_rd    = (mc == MC_READ) || ((mc == MC_FETCH) && !cyc_end);
  assign mem_wr    = (mc == MC_WRITE);
  assign mcycle    = mc;
  assign tstate    = ts;
  assign flags     = flag_q;
endmodule

// File: rtl/incr_core_chk.sv
module incr_core_chk
  import incr_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             mc_i,
  input logic [TS_W-1:0]        ts_i,
  input logic                   rd_i,
  input logic                   wr_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [DATA_W-1:0]      flags_i,
  input logic [NREG*DATA_W-1:0] regs_i,
  input logic                   fetch_start_i
);
  logic [ADDR_W-1:0] last_fetch;
  logic              seen_fetch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_fetch <= '0;
      seen_fetch <= 1'b0;
    end else if (fetch_start_i) begin
      last_fetch <= addr_i;
      seen_fetch <= 1'b1;
    end
  end

  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i && wr_i));

  assert_t4_only_in_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_i == 3'd4) |-> (mc_i == 2'b01));

  assert_tstate_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_i != 3'd1) |-> (ts_i == $past(ts_i) + 3'd1));

  assert_new_cycle_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_i != $past(mc_i)) |-> (ts_i == 3'd1));

  assert_read_after_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_i == 2'b10 && ts_i == 3'd1) |-> ($past(mc_i) == 2'b01));

  assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_i == 2'b11 && ts_i == 3'd1) |-> ($past(mc_i) == 2'b10));

  assert_regs_hold_in_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_i != 2'b01) |=> $stable(regs_i));

  assert_carry_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> $stable(flags_i[F_CY]));

  assert_unused_flag_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i[5] == 1'b0) && (flags_i[3] == 1'b0) && (flags_i[1] == 1'b0));

  assert_pc_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start_i && seen_fetch) |-> (addr_i == last_fetch + 1'b1));
endmodule

bind incr_core incr_core_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mc_i          (mcycle),
  .ts_i          (tstate),
  .rd_i          (mem_rd),
  .wr_i          (mem_wr),
  .addr_i        (mem_addr),
  .flags_i       (flags),
  .regs_i        (arch_regs),
  .fetch_start_i (fetch_start)
);

// File: tb/tb_incr_core.sv
`timescale 1ns/1ps
module tb_incr_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;
  logic        mem_rd, mem_wr;
  logic [1:0]  mcycle;
  logic [2:0]  tstate;
  logic [63:0] arch_regs;
  logic [7:0]  flags;

  always #2 clk = ~clk;

  incr_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mcycle(mcycle),
    .tstate(tstate), .arch_regs(arch_regs), .flags(flags)
  );

  // Bench memory: 4K bytes, aliased on the low address bits.
  logic [7:0]  mem [0:4095];
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  always @(posedge clk) begin
    if (ld_en)       mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
  end
  assign mem_rdata = mem[mem_addr[11:0]];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(input logic [11:0] a, input logic [7:0] d);
    ld_addr = a; ld_data = d; ld_en = 1'b1;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  // Flag model written from the requirement text.
  function automatic logic [7:0] exp_flags_of(input logic [7:0] r, input logic cy);
    int ones = 0;
    logic [7:0] f = 8'h00;
    for (int b = 0; b < 8; b++) ones += int'(r[b]);
    if (r >= 8'h80)     f = f | 8'h80;
    if (r == 8'h00)     f = f | 8'h40;
    if (r[3:0] == 4'h0) f = f | 8'h10;
    if (ones % 2 == 0)  f = f | 8'h04;
    if (cy)             f = f | 8'h01;
    return f;
  endfunction

  // {opcode, length, kind(0 none,1 reg,2 mem), address, expected value}
  localparam int NV = 17;
  localparam logic [39:0] VEC [NV] = '{
    {8'h00, 4'd4,  4'd0, 16'h0000, 8'h00},  // R2 no-op
    {8'h24, 4'd4,  4'd1, 16'h0000, 8'h01},  // R3 H
    {8'h2C, 4'd4,  4'd1, 16'h0000, 8'h01},  // R3 L
    {8'h34, 4'd10, 4'd2, 16'h0101, 8'h06},  // R4 memory 05 -> 06
    {8'h3C, 4'd4,  4'd1, 16'h0000, 8'h01},  // R3 A
    {8'h0C, 4'd4,  4'd1, 16'h0000, 8'h01},  // R3 C
    {8'h14, 4'd4,  4'd1, 16'h0000, 8'h01},  // R3 D
    {8'h1C, 4'd4,  4'd1, 16'h0000, 8'h01},  // R3 E
    {8'h04, 4'd4,  4'd1, 16'h0000, 8'h01},  // R3 B
    {8'h2C, 4'd4,  4'd1, 16'h0000, 8'h02},  // R3 L again
    {8'h34, 4'd10, 4'd2, 16'h0102, 8'h00},  // R6 memory FF -> 00
    {8'h76, 4'd4,  4'd0, 16'h0000, 8'h00},  // R7 unlisted opcode
    {8'h34, 4'd10, 4'd2, 16'h0102, 8'h01},  // R4 memory 00 -> 01
    {8'h2C, 4'd4,  4'd1, 16'h0000, 8'h03},  // R3 L again
    {8'h34, 4'd10, 4'd2, 16'h0103, 8'h80},  // R5 memory 7F -> 80
    {8'hC3, 4'd4,  4'd0, 16'h0000, 8'h00},  // R7 unlisted opcode
    {8'h3C, 4'd4,  4'd1, 16'h0000, 8'h02}   // R3 A again
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  exp_regs [8];
    logic [7:0]  exp_f;
    logic [15:0] exp_pc;
    for (int i = 0; i < 8; i++) exp_regs[i] = 8'h00;
    exp_f = 8'h00;
    exp_pc = 16'h0000;

    for (int a = 0; a < 4096; a++) load(12'(a), 8'h00);
    for (int i = 0; i < NV; i++) load(12'(i), VEC[i][39:32]);
    load(12'h101, 8'h05);
    load(12'h102, 8'hFF);
    load(12'h103, 8'h7F);

    @(negedge clk);
    // R1 reset state
    chk(arch_regs == 64'h0, "R1 regs", arch_regs, 64'h0);
    chk(flags == 8'h00, "R1 flags", flags, 8'h00);
    chk(mcycle == 2'b01 && tstate == 3'd1, "R1 cycle", {mcycle, tstate}, {2'b01, 3'd1});
    chk(mem_addr == 16'h0000 && !mem_wr, "R1 bus", {mem_wr, mem_addr}, 17'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [7:0]  op;
      int          len, kind;
      logic [15:0] addr;
      logic [7:0]  val;
      op = VEC[i][39:32]; len = int'(VEC[i][31:28]); kind = int'(VEC[i][27:24]);
      addr = VEC[i][23:8]; val = VEC[i][7:0];
      for (int k = 0; k < len; k++) begin
        logic [1:0] emc;
        logic [2:0] ets;
        bit         erd, ewr;
        if (k < 4)      begin emc = 2'b01; ets = 3'(k + 1); end
        else if (k < 7) begin emc = 2'b10; ets = 3'(k - 3); end
        else            begin emc = 2'b11; ets = 3'(k - 6); end
        erd = (emc == 2'b01 && ets != 3'd4) || emc == 2'b10;
        ewr = (emc == 2'b11);
        chk(mcycle == emc && tstate == ets, "R8 cycle/tstate", {mcycle, tstate}, {emc, ets});
        chk(mem_rd == erd && mem_wr == ewr, "R9 strobes", {mem_rd, mem_wr}, {erd, ewr});
        if (k == 0) chk(mem_addr == exp_pc, "R10 fetch address", mem_addr, exp_pc);
        if (k >= 4) chk(mem_addr == addr, "R4 H:L address", mem_addr, addr);
        if (ewr) chk(mem_wdata == val, "R4 write data", mem_wdata, val);
        @(negedge clk);
      end
      exp_pc = exp_pc + 16'd1;
      if (kind == 1) exp_regs[op[5:3]] = val;
      if (kind != 0) exp_f = exp_flags_of(val, exp_f[0]);
      for (int r = 0; r < 8; r++)
        chk(arch_regs[r*8 +: 8] == exp_regs[r],
            (kind == 0) ? "R2/R7 regs unchanged" : "R3 register result",
            arch_regs[r*8 +: 8], exp_regs[r]);
      chk(flags == exp_f, (kind == 0) ? "R2/R7 flags unchanged" : "R5 flags", flags, exp_f);
      if (kind == 2) chk(mem[addr[11:0]] == val, "R4 memory result", mem[addr[11:0]], val);
    end
    chk(flags == 8'h00 && mem[12'h103] == 8'h80, "R5 sign set then cleared by A", {flags, mem[12'h103]}, 16'h0080);

    // Directed: register wrap through 256 increments of B.
    rst_n = 1'b0;
    for (int a = 0; a < 260; a++) load(12'(a), 8'h04);
    @(negedge clk);
    chk(arch_regs == 64'h0 && flags == 8'h00, "R1 reset again", {flags, arch_regs}, 72'h0);
    rst_n = 1'b1;
    repeat (255 * 4) @(negedge clk);
    chk(arch_regs[7:0] == 8'hFF, "R3 B reaches FF", arch_regs[7:0], 8'hFF);
    chk(flags == 8'h84, "R5 flags at FF", flags, 8'h84);
    chk(mem_addr == 16'd255, "R10 pc after 255 fetches", mem_addr, 16'd255);
    repeat (4) @(negedge clk);
    chk(arch_regs[7:0] == 8'h00, "R6 B wraps", arch_regs[7:0], 8'h00);
    chk(flags == 8'h54, "R6 zero and half-carry set", flags, 8'h54);
    chk(arch_regs[63:8] == 56'h0, "R3 other registers untouched", arch_regs[63:8], 56'h0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule